// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous static memory. Its data bus never needs an idle cycle when the traffic switches between reads and writes. On each rising clock edge where the clock enable is high, the memory captures an address and a write flag. The data for that access then crosses the bus a fixed number of enabled edges later. This delay is the same for reads and for writes, so any mix of accesses can be issued back to back and every data cycle is used.

A build-time parameter chooses between two latencies:

- **Flow-through:** one cycle of data latency. Read data comes straight from the array.
- **Pipelined:** two cycles of data latency. One extra output register sits in the read path.

Write data is presented on a separate input port. Read data leaves on a separate output port, together with a drive indication that shows when that port carries valid read data. The output enable gates the drive indication and the read data without waiting for a clock edge. Every other action happens on the rising clock edge.

Top module: `zbt_sram`

## Requirements
- R1: A synchronous reset drops every access in flight, so `rdata_drive` is low until a read issued after the reset reaches its data phase. Reset leaves the stored words unchanged.
- R2: In flow-through mode (`PIPELINED`=0), a read accepted at enabled edge k drives its word on `rdata`, with `rdata_drive` high, from edge k until the next enabled edge.
- R3: In pipelined mode (`PIPELINED`=1), a read accepted at enabled edge k drives its word from the following enabled edge until the one after it.
- R4: A write accepted at enabled edge k stores the `wdata` value sampled at the enabled edge that is LAT edges later. LAT is 1 in flow-through mode and 2 in pipelined mode. `wdata` at every other edge has no effect on the contents.
- R5: Reads and writes in any order, including strict alternation with clock enable held high, each use exactly one data cycle and need no idle cycles between them. A write's data cycle never drives `rdata`.
- R6: A read issued on the enabled edge right after a write to the same address returns that write's data.
- R7: An edge with `clk_en` low does not change any pipeline stage. It writes nothing, and it leaves `rdata` and `rdata_drive` as they were.
- R8: While `out_en` is low, `rdata_drive` is low and `rdata` is all zeros, without a clock edge being needed. `rdata` is also all zeros whenever `rdata_drive` is low. Switching `out_en` does not disturb the accesses in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the access pipeline |
| clk_en | input | 1 | High: this edge accepts an access and advances the pipeline |
| addr | input | AW | Word address of the access |
| wr_en | input | 1 | 1 = write access, 0 = read access |
| out_en | input | 1 | Asynchronous gate on the read data output |
| wdata | input | DW | Write data, sampled in the write's data phase |
| rdata | output | DW | Read data; zero when not driving |
| rdata_drive | output | 1 | High while `rdata` carries a read's word |

## Verification
The hardest case to reach is a write whose commit edge is the same edge on which a younger read to the same address fetches its word. This only happens in pipelined mode. It needs the two accesses on consecutive enabled edges, and clock-enable stalls may fall between them.

The bench reaches this case with write-then-read pairs to one address, in bursts and with stalls inserted. It drives the two instances, flow-through and pipelined, from one access stream. Each instance gets the write data that belongs to its own data phase, and junk is placed on the data input at every other edge. An in-order reference memory then predicts each word.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

    // Kind of access held in a pipeline stage.
    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

    // Number of enabled edges between the address edge and the data edge.
    function automatic int unsigned data_lat(bit pipelined);
        return pipelined ? 2 : 1;
    endfunction

endpackage

// File: rtl/zbt_req_pipe.sv
`timescale 1ns/1ps
module zbt_req_pipe
    import zbt_pkg::*;
#(
    parameter int unsigned AW    = 6,
    parameter int unsigned DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    output logic          head_vld,
    output logic          head_wr,
    output logic [AW-1:0] head_addr,
    output logic          tail_vld,
    output logic          tail_wr,
    output logic [AW-1:0] tail_addr
);

    typedef struct packed {
        logic          vld;
        acc_e          kind;
        logic [AW-1:0] addr;
    } stage_t;

    stage_t fresh;
    stage_t stg [DEPTH];

    always_comb begin
        fresh.vld  = 1'b1;
        fresh.kind = wr_en ? ACC_WRITE : ACC_READ;
        fresh.addr = addr;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)         stg[g] <= '0;
                else if (clk_en) stg[g] <= fresh;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)         stg[g] <= '0;
                else if (clk_en) stg[g] <= stg[g-1];
            end
        end
    end

    assign head_vld  = stg[0].vld;
    assign head_wr   = (stg[0].kind == ACC_WRITE);
    assign head_addr = stg[0].addr;
    assign tail_vld  = stg[DEPTH-1].vld;
    assign tail_wr   = (stg[DEPTH-1].kind == ACC_WRITE);
    assign tail_addr = stg[DEPTH-1].addr;

endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
module zbt_array #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int unsigned AW        = 6,
    parameter int unsigned DW        = 16,
    parameter bit          PIPELINED = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          out_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_drive
);

    localparam int unsigned LAT = data_lat(PIPELINED);

    logic          head_vld, head_wr, tail_vld, tail_wr;
    logic [AW-1:0] head_addr, tail_addr;
    logic          commit;
    logic [DW-1:0] arr_word;
    logic [DW-1:0] rd_word;
    logic          rd_live;

    zbt_req_pipe #(.AW(AW), .DEPTH(LAT)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .head_vld  (head_vld),
        .head_wr   (head_wr),
        .head_addr (head_addr),
        .tail_vld  (tail_vld),
        .tail_wr   (tail_wr),
        .tail_addr (tail_addr)
    );

    // The write lands when its delayed flag meets the sampled data.
    assign commit = clk_en & tail_vld & tail_wr;

    zbt_array #(.AW(AW), .DW(DW)) u_array (
        .clk     (clk),
        .wr_en   (commit),
        .wr_addr (tail_addr),
        .wr_data (wdata),
        .rd_addr (head_addr),
        .rd_data (arr_word)
    );

    if (PIPELINED) begin : g_pipe_out
        logic          bypass;
        logic [DW-1:0] out_q;
        logic          live_q;

        // A write commits on the same edge that the next read loads its word.
        assign bypass = tail_vld & tail_wr & (tail_addr == head_addr);

        always_ff @(posedge clk) begin
            if (rst) begin
                live_q <= 1'b0;
                out_q  <= '0;
            end else if (clk_en) begin
                live_q <= head_vld & ~head_wr;
                out_q  <= bypass ? wdata : arr_word;
            end
        end

        assign rd_word = out_q;
        assign rd_live = live_q;
    end else begin : g_flow_out
        assign rd_word = arr_word;
        assign rd_live = head_vld & ~head_wr;
    end

    assign rdata_drive = rd_live & out_en;
    assign rdata       = rdata_drive ? rd_word : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
`timescale 1ns/1ps
module zbt_sram_chk #(
    parameter int unsigned AW        = 6,
    parameter int unsigned DW        = 16,
    parameter bit          PIPELINED = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          clk_en,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic          out_en,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic          rdata_drive
);

    // Edges since reset was released, saturating.
    logic [2:0] since;

    always_ff @(posedge clk) begin
        if (rst)               since <= '0;
        else if (since != 3'd7) since <= since + 3'd1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rdata_drive);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (since >= 3'd1 && !$past(clk_en) && $stable(out_en))
            |-> ($stable(rdata) && $stable(rdata_drive)));

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (!rdata_drive && rdata == '0));

    if (PIPELINED) begin : g_pipe
        assert_drive_lat_R3: assert property (@(posedge clk) disable iff (rst)
            (since >= 3'd2 && $past(clk_en) && $past(clk_en, 2) && out_en)
                |-> (rdata_drive == !$past(wr_en, 2)));

        assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
            (since >= 3'd3 && $past(clk_en) && $past(clk_en, 2) && $past(clk_en, 3)
             && $past(wr_en, 3) && !$past(wr_en, 2)
             && $past(addr, 3) == $past(addr, 2) && out_en)
                |-> (rdata == $past(wdata)));
    end else begin : g_flow
        assert_drive_lat_R2: assert property (@(posedge clk) disable iff (rst)
            (since >= 3'd1 && $past(clk_en) && out_en)
                |-> (rdata_drive == !$past(wr_en)));

        assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
            (since >= 3'd2 && $past(clk_en) && $past(clk_en, 2)
             && $past(wr_en, 2) && !$past(wr_en)
             && $past(addr, 2) == $past(addr) && out_en)
                |-> (rdata == $past(wdata)));
    end

endmodule

bind zbt_sram zbt_sram_chk #(.AW(AW), .DW(DW), .PIPELINED(PIPELINED)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clk_en      (clk_en),
    .addr        (addr),
    .wr_en       (wr_en),
    .out_en      (out_en),
    .wdata       (wdata),
    .rdata       (rdata),
    .rdata_drive (rdata_drive)
);

// File: tb/sim_zbt_sram.sv
`timescale 1ns/1ps
module sim_zbt_sram;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        out_en = 1'b1;
    logic [5:0]  addr = '0;
    logic [15:0] wd_pipe = '0, wd_flow = '0;
    logic [15:0] rd_pipe, rd_flow;
    logic        dr_pipe, dr_flow;

    always #4 clk = ~clk;   // 125 MHz

    zbt_sram #(.AW(6), .DW(16), .PIPELINED(1'b1)) u0 (
        .clk(clk), .rst(rst), .clk_en(clk_en), .addr(addr), .wr_en(wr_en),
        .out_en(out_en), .wdata(wd_pipe), .rdata(rd_pipe), .rdata_drive(dr_pipe));

    zbt_sram #(.AW(6), .DW(16), .PIPELINED(1'b0)) u1 (
        .clk(clk), .rst(rst), .clk_en(clk_en), .addr(addr), .wr_en(wr_en),
        .out_en(out_en), .wdata(wd_flow), .rdata(rd_flow), .rdata_drive(dr_flow));

    int n_cmp = 0, n_bad = 0;
    int acc_n = 0, base = 0, cyc_no = 0;
    logic        h_we   [1024];
    logic [5:0]  h_addr [1024];
    logic [15:0] h_data [1024];
    logic [15:0] h_exp  [1024];
    logic [15:0] ref_mem [64];

    function automatic logic [15:0] pick(int i);
        if (i >= base && i >= 0 && h_we[i]) return h_data[i];
        return 16'hBAD0 ^ cyc_no[15:0];
    endfunction

    task automatic chk_port(input logic [15:0] d, input logic dr, input int i,
                            input string which, input string tag);
        logic        e_dr;
        logic [15:0] e_d;
        e_dr = (i >= base && i >= 0 && !h_we[i] && out_en);
        e_d  = e_dr ? h_exp[i] : 16'h0000;
        n_cmp++;
        if (dr !== e_dr || d !== e_d) begin
            n_bad++;
            $display("FAIL %s %s: rdata=%h drive=%b expected rdata=%h drive=%b",
                     tag, which, d, dr, e_d, e_dr);
        end
    endtask

    // One clock: check the outputs left by the last edge, then present the next access.
    task automatic cyc(input logic ce_v, input logic we_v, input logic [5:0] a_v,
                       input logic [15:0] d_v, input logic oe_v, input string tag);
        @(negedge clk);
        cyc_no++;
        out_en = oe_v;
        #1;
        chk_port(rd_flow, dr_flow, acc_n - 1, "flow", tag);
        chk_port(rd_pipe, dr_pipe, acc_n - 2, "pipe", tag);
        clk_en = ce_v;
        wr_en  = we_v;
        addr   = a_v;
        if (ce_v) begin
            wd_flow = pick(acc_n - 1);
            wd_pipe = pick(acc_n - 2);
            h_we[acc_n]   = we_v;
            h_addr[acc_n] = a_v;
            h_data[acc_n] = d_v;
            if (we_v) ref_mem[a_v] = d_v;
            else      h_exp[acc_n] = ref_mem[a_v];
            acc_n++;
        end else begin
            wd_flow = 16'h5A5A ^ cyc_no[15:0];
            wd_pipe = 16'hA5A5 ^ cyc_no[15:0];
        end
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        cyc(1'b1, 1'b0, a, 16'h0000, 1'b1, tag);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d, input string tag);
        cyc(1'b1, 1'b1, a, d, 1'b1, tag);
    endtask

    task automatic t_reset_start();
        rst = 1'b1; clk_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        base = acc_n;
        repeat (2) cyc(1'b0, 1'b1, 6'd3, 16'h0, 1'b1, "R1");
    endtask

    task automatic t_fill();
        for (int i = 0; i < 64; i++) wr(i[5:0], 16'h1000 + 16'(i * 37), "R4 R5");
    endtask

    task automatic t_read_back();
        for (int i = 63; i >= 0; i--) rd(i[5:0], "R2 R3");
    endtask

    task automatic t_data_window();
        // Junk sits on wdata at every edge outside each write's own data phase.
        rd(6'd7, "R4");
        wr(6'd7, 16'hC0DE, "R4");
        rd(6'd8, "R4");
        rd(6'd8, "R4");
        wr(6'd8, 16'h7777, "R4");
        rd(6'd1, "R4");
        rd(6'd7, "R4");
        rd(6'd8, "R4");
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 16; i++) begin
            wr(6'(20 + i), 16'h2000 + 16'(i), "R5");
            rd(6'(19 + i), "R5");
        end
        rd(6'd35, "R5");
    endtask

    task automatic t_bypass();
        wr(6'd5, 16'hAAAA, "R6");
        rd(6'd5, "R6");
        wr(6'd5, 16'hBBBB, "R6");
        wr(6'd5, 16'hCCCC, "R6");
        rd(6'd5, "R6");
        wr(6'd9, 16'hDDDD, "R6");
        rd(6'd9, "R6");
        rd(6'd9, "R6");
    endtask

    task automatic t_stall();
        wr(6'd10, 16'h1111, "R7");
        cyc(1'b0, 1'b1, 6'd10, 16'hFFFF, 1'b1, "R7");
        cyc(1'b0, 1'b1, 6'd10, 16'hEEEE, 1'b1, "R7");
        rd(6'd10, "R7");
        cyc(1'b0, 1'b0, 6'd11, 16'h0, 1'b1, "R7");
        wr(6'd11, 16'h2222, "R7");
        cyc(1'b0, 1'b1, 6'd11, 16'h9999, 1'b1, "R7");
        rd(6'd11, "R7");
        cyc(1'b0, 1'b1, 6'd12, 16'h8888, 1'b1, "R7");
        cyc(1'b0, 1'b1, 6'd12, 16'h8888, 1'b1, "R7");
        rd(6'd11, "R7");
        rd(6'd12, "R7");
        rd(6'd10, "R7");
    endtask

    task automatic t_oe();
        rd(6'd20, "R8");
        cyc(1'b1, 1'b0, 6'd21, 16'h0, 1'b0, "R8");
        cyc(1'b1, 1'b0, 6'd22, 16'h0, 1'b0, "R8");
        cyc(1'b1, 1'b1, 6'd23, 16'h4321, 1'b0, "R8");
        rd(6'd23, "R8");
        cyc(1'b0, 1'b0, 6'd23, 16'h0, 1'b0, "R8");
        rd(6'd21, "R8");
        rd(6'd22, "R8");
    endtask

    task automatic t_reset_mid();
        rd(6'd30, "R1");
        rd(6'd31, "R1");
        rd(6'd32, "R1");
        @(negedge clk);
        rst = 1'b1; clk_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        base = acc_n;
        cyc(1'b0, 1'b0, 6'd0, 16'h0, 1'b1, "R1");
        cyc(1'b0, 1'b0, 6'd0, 16'h0, 1'b1, "R1");
        rd(6'd30, "R1");
        rd(6'd5, "R1");
        rd(6'd63, "R1");
    endtask

    initial begin
        t_reset_start();
        t_fill();
        t_read_back();
        t_data_window();
        t_alternate();
        t_bypass();
        t_stall();
        t_oe();
        t_reset_mid();
        repeat (3) rd(6'd0, "R2 R3");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog R1: run still active, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule